// File: doc/BRIEF.md
# Lockable System-Management Memory Window Controller

This block holds the 8-bit control register for the legacy system-management memory window, which covers addresses A0000h to BFFFFh, and performs the decode that uses that register. On the configuration side, a one-cycle write strobe loads the register and a combinational read port returns its contents. On the memory side, each request carries an address, a flag that marks it as an instruction (code) fetch, and a flag that says whether system-management mode is active. One cycle later the block reports whether the request reaches the protected DRAM behind the window or is passed on as an ordinary video-range access. Requests outside the window are reported as neither. The DRAM address is never remapped; the block only makes that memory visible.

The register has three writable controls: an open bit, a closed bit and a write-once lock.
- The open bit exposes the window to every request.
- The closed bit hides the window from data fetches, even in system-management mode. Code fetches in that mode still reach the DRAM.
- Once the lock is set, it forces the open bit to zero and keeps it there. Only a full reset clears the lock. A warm reset clears the open and closed bits but leaves the lock alone.

A write that asks for open and closed together is refused for both bits, and the block raises an error pulse.

Top module: `smw_window_ctl`

## Requirements
- R1: After a full reset the read port returns 8'h02.
- R2: Read bits 2:0 always return 3'b010 and read bits 7 and 3 always return 0, whatever value was written.
- R3: While unlocked, a write stores wdata bit 6 as the open bit and wdata bit 5 as the closed bit. Both read back at the same bit positions.
- R4: Writing 1 to wdata bit 4 sets the lock, which reads back at bit 4. Writing 0 never clears it, and neither does a warm reset. A full reset clears it.
- R5: While the lock is set, or in the write that sets it, the open bit becomes 0 and later writes cannot set it. The closed bit stays writable.
- R6: A warm reset clears the open and closed bits.
- R7: A write with wdata bits 6 and 5 both 1 leaves the open and closed bits unchanged. It raises wr_err for exactly the cycle after the write edge. Open and closed never read 1 together.
- R8: A request inside A0000h..BFFFFh goes to DRAM when win_en=1 and (open=1, or (smm_active=1 and (closed=0 or req_code=1)))).
- R9: A request inside the window that fails R8 goes to video. A request outside the window (for example 9FFFFh or C0000h) asserts neither route.
- R10: The decode result and dec_valid appear on the clock edge that samples req_valid, which is one cycle of latency. The route outputs are 0 whenever dec_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_full_n | input | 1 | Synchronous active-low full reset, clears everything including the lock |
| rst_warm_n | input | 1 | Synchronous active-low warm reset, clears all but the lock |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| req_valid | input | 1 | Memory request present |
| req_addr | input | ADDR_W | Request address |
| req_code | input | 1 | 1 = code fetch, 0 = data fetch |
| smm_active | input | 1 | System-management mode active |
| win_en | input | 1 | Window enable from the surrounding configuration |
| dec_valid | output | 1 | Decode result valid |
| dec_dram | output | 1 | Request goes to protected DRAM |
| dec_video | output | 1 | Request goes to the video range |
| wr_err | output | 1 | Pulse: a write requested open and closed together |

## Verification
Register effects show on cfg_rdata right after the write edge. wr_err is registered on that same edge. Decode results appear one edge after req_valid is sampled. The bench drives every stimulus on a falling edge and samples on the next falling edge, so each result is read half a cycle after the rising edge that produces it. The decode sweep covers every combination of mode, fetch type, enable and open/closed state at the window boundaries and just outside them. The expected route for each case is computed in the bench from the rule in R8.

// File: rtl/smw_pkg.sv
// Shared constants and types for the system-management window controller.
// Assumes the window is the fixed legacy range A0000h..BFFFFh.
package smw_pkg;
    localparam int          REG_W      = 8;
    localparam int          BIT_OPEN   = 6;
    localparam int          BIT_CLOSED = 5;
    localparam int          BIT_LOCK   = 4;
    localparam logic [2:0]  SEG_CODE   = 3'b010;
    localparam logic [31:0] WIN_BASE   = 32'h000A_0000;
    localparam logic [31:0] WIN_LAST   = 32'h000B_FFFF;

    typedef struct packed {
        logic open;
        logic closed;
        logic lock;
    } smw_ctl_t;

    // Assemble read data: reserved bits are zero, segment field is fixed.
    function automatic logic [REG_W-1:0] pack_rd(smw_ctl_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[BIT_OPEN]   = c.open;
        r[BIT_CLOSED] = c.closed;
        r[BIT_LOCK]   = c.lock;
        r[2:0]        = SEG_CODE;
        return r;
    endfunction
endpackage

// File: rtl/smw_ctl_reg.sv
// Control register state: open, closed and the write-once lock.
// Assumes both resets are synchronous and active low; the full reset wins.
// A write asking for open and closed together keeps both and flags an error.
module smw_ctl_reg
    import smw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_full_n,
    input  logic     rst_warm_n,
    input  logic     wr_en,
    input  logic     wr_open,
    input  logic     wr_closed,
    input  logic     wr_lock,
    output smw_ctl_t ctl,
    output logic     wr_err
);
    logic conflict;
    logic lock_next;

    // Detect an illegal open+closed request and the lock value after a write.
    always_comb begin
        conflict  = wr_open & wr_closed;
        lock_next = ctl.lock | wr_lock;
    end

    // Register update with reset precedence full > warm > write.
    always_ff @(posedge clk) begin
        if (!rst_full_n) begin
            ctl    <= '0;
            wr_err <= 1'b0;
        end else if (!rst_warm_n) begin
            ctl.open   <= 1'b0;
            ctl.closed <= 1'b0;
            wr_err     <= 1'b0;
        end else begin
            wr_err <= 1'b0;
            if (wr_en) begin
                ctl.lock <= lock_next;
                if (!conflict)
                    ctl.closed <= wr_closed;
                if (lock_next)
                    ctl.open <= 1'b0;
                else if (!conflict)
                    ctl.open <= wr_open;
                wr_err <= conflict;
            end
        end
    end

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_full_n)
        ctl.lock |=> ctl.lock);
    a_r5_locked_open_low: assert property (@(posedge clk) disable iff (!rst_full_n)
        ctl.lock |-> !ctl.open);
    a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_full_n)
        !(ctl.open && ctl.closed));
    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_full_n || !rst_warm_n)
        wr_err |-> $past(wr_en && wr_open && wr_closed));
    a_r6_warm_clear: assert property (@(posedge clk) disable iff (!rst_full_n)
        !$past(rst_warm_n) |-> (!ctl.open && !ctl.closed));
endmodule

// File: rtl/smw_addr_match.sv
// Range compare of a request address against an inclusive window.
// Assumes BASE <= LAST; purely combinational.
module smw_addr_match #(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter logic [ADDR_W-1:0] LAST   = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Inclusive bounds check.
    always_comb hit = (addr >= BASE) && (addr <= LAST);
endmodule

// File: rtl/smw_route.sv
// Access decision for one request: DRAM, video, or neither (outside window).
// OUT_REG selects a registered (1) or combinational (0) result.
module smw_route
    import smw_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     in_win,
    input  logic     req_code,
    input  logic     smm_active,
    input  logic     win_en,
    input  smw_ctl_t ctl,
    output logic     dec_valid,
    output logic     dec_dram,
    output logic     dec_video
);
    logic permit, nx_dram, nx_video;

    // Apply the visibility rule; closed hides only data fetches.
    always_comb begin
        permit   = win_en & (ctl.open | (smm_active & (~ctl.closed | req_code)));
        nx_dram  = req_valid & in_win & permit;
        nx_video = req_valid & in_win & ~permit;
    end

    generate
        if (OUT_REG) begin : g_reg
            // One-cycle output stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dec_valid <= 1'b0;
                    dec_dram  <= 1'b0;
                    dec_video <= 1'b0;
                end else begin
                    dec_valid <= req_valid;
                    dec_dram  <= nx_dram;
                    dec_video <= nx_video;
                end
            end
            a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid |=> dec_valid);
        end else begin : g_comb
            // Pass-through output.
            always_comb begin
                dec_valid = req_valid;
                dec_dram  = nx_dram;
                dec_video = nx_video;
            end
        end
    endgenerate

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_dram && dec_video));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_dram && !dec_video));
endmodule

// File: rtl/smw_window_ctl.sv
// Top: control register plus decode for the legacy system-management window.
// Assumes synchronous active-low resets; the decode stage clears on either.
module smw_window_ctl
    import smw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_full_n,
    input  logic              rst_warm_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_code,
    input  logic              smm_active,
    input  logic              win_en,
    output logic              dec_valid,
    output logic              dec_dram,
    output logic              dec_video,
    output logic              wr_err
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(WIN_LAST);

    smw_ctl_t ctl;
    logic     in_win;
    logic     pipe_rst_n;
    logic     unused_wbits;

    // Decode pipeline clears on either reset; reserved/fixed write bits dropped.
    always_comb begin
        pipe_rst_n   = rst_full_n & rst_warm_n;
        unused_wbits = ^{cfg_wdata[7], cfg_wdata[3], cfg_wdata[2:0]};
        cfg_rdata    = pack_rd(ctl);
    end

    smw_ctl_reg u_reg (
        .clk        (clk),
        .rst_full_n (rst_full_n),
        .rst_warm_n (rst_warm_n),
        .wr_en      (cfg_wr_en),
        .wr_open    (cfg_wdata[BIT_OPEN]),
        .wr_closed  (cfg_wdata[BIT_CLOSED]),
        .wr_lock    (cfg_wdata[BIT_LOCK]),
        .ctl        (ctl),
        .wr_err     (wr_err)
    );

    smw_addr_match #(.ADDR_W(ADDR_W), .BASE(BASE_A), .LAST(LAST_A)) u_match (
        .addr (req_addr),
        .hit  (in_win)
    );

    smw_route #(.OUT_REG(OUT_REG)) u_route (
        .clk        (clk),
        .rst_n      (pipe_rst_n),
        .req_valid  (req_valid),
        .in_win     (in_win),
        .req_code   (req_code),
        .smm_active (smm_active),
        .win_en     (win_en),
        .ctl        (ctl),
        .dec_valid  (dec_valid),
        .dec_dram   (dec_dram),
        .dec_video  (dec_video)
    );

    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_full_n)
        cfg_rdata[2:0] == 3'b010 && !cfg_rdata[7] && !cfg_rdata[3]);
endmodule

// File: tb/tb_smw_window_ctl.sv
`timescale 1ns/1ps
module tb_smw_window_ctl;
    logic        clk = 1'b0;
    logic        rst_full_n = 1'b0, rst_warm_n = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0, req_code = 1'b0, smm_active = 1'b0, win_en = 1'b0;
    logic [31:0] req_addr = '0;
    logic        dec_valid, dec_dram, dec_video, wr_err;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    bit  m_open = 0, m_closed = 0, m_lock = 0;

    always #2 clk = ~clk;

    smw_window_ctl dut (
        .clk(clk), .rst_full_n(rst_full_n), .rst_warm_n(rst_warm_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_code(req_code),
        .smm_active(smm_active), .win_en(win_en),
        .dec_valid(dec_valid), .dec_dram(dec_dram), .dec_video(dec_video),
        .wr_err(wr_err));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        return {1'b0, m_open, m_closed, m_lock, 1'b0, 3'b010};
    endfunction

    // Write and update the model; wr_err and rdata checked after the edge.
    task automatic wr(logic [7:0] d, string req);
        bit conf;
        conf = d[6] & d[5];
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr_en = 1'b0;
        m_lock = m_lock | d[4];
        if (!conf) m_closed = d[5];
        if (m_lock) m_open = 0; else if (!conf) m_open = d[6];
        check(req, cfg_rdata, exp_rd());
        check({req, " err"}, wr_err, conf);
        @(negedge clk);
        check({req, " err pulse"}, wr_err, 1'b0);
    endtask

    // One request; result sampled one edge later.
    task automatic dec(logic [31:0] a, bit code, bit smm, bit en);
        bit inw, perm;
        inw  = (a >= 32'hA0000) && (a <= 32'hBFFFF);
        perm = en && (m_open || (smm && (!m_closed || code)));
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_code = code; smm_active = smm; win_en = en;
        @(negedge clk); req_valid = 1'b0;
        check("R10 valid", dec_valid, 1'b1);
        check("R8 dram", dec_dram, inw && perm);
        check("R9 video", dec_video, inw && !perm);
        @(negedge clk);
        check("R10 idle", {dec_valid, dec_dram, dec_video}, 3'b000);
    endtask

    task automatic sweep();
        logic [31:0] addrs [5] = '{32'h9FFFF, 32'hA0000, 32'hB1234, 32'hBFFFF, 32'hC0000};
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 2; c++)
                for (int e = 0; e < 2; e++)
                    for (int k = 0; k < 5; k++)
                        dec(addrs[k], c[0], s[0], e[0]);
    endtask

    task automatic full_reset();
        @(negedge clk); rst_full_n = 1'b0;
        @(negedge clk); rst_full_n = 1'b1;
        m_open = 0; m_closed = 0; m_lock = 0;
    endtask

    task automatic warm_reset();
        @(negedge clk); rst_warm_n = 1'b0;
        @(negedge clk); rst_warm_n = 1'b1;
        m_open = 0; m_closed = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_full_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", cfg_rdata, 8'h02);
        check("R1 no err", wr_err, 1'b0);
        // R2: reserved and fixed bits ignore writes
        wr(8'h8F, "R2 fixed bits");
        // R3 and R8/R9 sweep per unlocked state
        wr(8'h00, "R3 clear"); sweep();
        wr(8'h40, "R3 open");  sweep();
        wr(8'h20, "R3 closed"); sweep();
        // R7: conflict refused from each state
        wr(8'h60, "R7 conflict closed");
        wr(8'h40, "R3 open again");
        wr(8'h60, "R7 conflict open");
        // R6: warm reset clears open/closed
        warm_reset();
        check("R6 warm", cfg_rdata, 8'h02);
        // R5: lock in same write as open -> open 0
        wr(8'h50, "R5 lock with open");
        wr(8'h40, "R5 open ignored");
        wr(8'h00, "R4 write 0 keeps lock");
        wr(8'h20, "R5 closed writable");
        sweep();
        wr(8'h60, "R7 conflict locked");
        warm_reset();
        check("R4 lock survives warm", cfg_rdata, 8'h12);
        sweep();
        full_reset();
        check("R4 full reset clears", cfg_rdata, 8'h02);
        wr(8'h40, "R4 open after unlock");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule